// File: doc/BRIEF.md
# Audio Master and Bit Clock Divider

This block produces the two clocks that one direction of a multichannel audio serial port needs. The first is a high-rate master clock. The second is a serial bit clock derived from it. Two free-running source clocks come in as square-wave levels, either a crystal input or a system clock. They are sampled in the block's own clock domain `clk`. The selected source's rising edges pass through a prescaler of 1 or 8, then a modulus counter of 1 to 256, then a halving toggle. The result is the master clock at a ratio of 2·P·M source periods. A frame-rate stage of 1 to 16 then divides the master clock down to the bit clock.

A bypass routes the crystal level straight to the master clock output at a ratio of 1. In that mode the bit clock ratio comes from the 1–16 stage alone. Drive bits choose whether the master clock pin, the bit clock pin and the frame sync pin are outputs. An undriven clock output is held low with its enable cleared. Separate polarity bits invert the master clock and the bit clock.

Every divider is a down-counter that reloads from its configuration input only at terminal count. A divide value that changes mid-phase therefore never produces a shortened phase.

Top module: `audio_clk_divider`

## Requirements
- R1: With bypass off, the master clock period equals 2·P·M periods of the selected source, with 50% duty. `src_sel_i`=0 selects the crystal input and 1 selects the system input.
- R2: `pre8_i`=1 sets the prescale factor P to 8, and `pre8_i`=0 sets P to 1.
- R3: The modulus factor M equals `mod_code_i`+1, so codes 0..255 give 1..256.
- R4: The bit clock period equals F master clock periods, with F = `frm_code_i`+1. An even F gives equal high and low phases.
- R5: An odd F above 1 keeps the bit clock high for (F+1)/2 master periods. F=1 makes the bit clock follow the master clock waveform.
- R6: With `bypass_i`=1 the master clock reproduces the crystal waveform at ratio 1, whatever the value of `src_sel_i`. The bit clock is then the crystal divided by F.
- R7: With `mclk_drive_i`=0, `hck_o` and `hck_oe_o` stay low. With `bclk_drive_i`=0, `sck_o` and `sck_oe_o` stay low. `fs_oe_o` follows `fs_drive_i` one cycle later.
- R8: `mclk_inv_i` inverts the master clock output and `bclk_inv_i` inverts the bit clock output, each independently of the other.
- R9: A changed divide code takes effect only at the stage's next terminal count. Every phase observed after the change has either the full old length or the full new length.
- R10: While synchronous reset `rst` is high, all outputs are low, and the clocks restart from cleared counters after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_i | input | 1 | Crystal source clock level |
| sys_i | input | 1 | System source clock level |
| src_sel_i | input | 1 | Source select: 0 crystal, 1 system |
| pre8_i | input | 1 | Prescale by 8 when 1, by 1 when 0 |
| mod_code_i | input | MOD_W | Modulus minus one |
| frm_code_i | input | FRM_W | Frame-rate divide minus one |
| bypass_i | input | 1 | Route the crystal directly to the master clock |
| mclk_drive_i | input | 1 | Master clock pin is driven |
| bclk_drive_i | input | 1 | Bit clock pin is driven |
| fs_drive_i | input | 1 | Frame sync pin is driven |
| mclk_inv_i | input | 1 | Invert the master clock |
| bclk_inv_i | input | 1 | Invert the bit clock |
| hck_o | output | 1 | Master clock output |
| hck_oe_o | output | 1 | Master clock pin output enable |
| sck_o | output | 1 | Bit clock output |
| sck_oe_o | output | 1 | Bit clock pin output enable |
| fs_oe_o | output | 1 | Frame sync pin output enable |

## Verification
A source edge reaches the master and bit clock outputs three `clk` cycles later: one synchroniser stage, one counter update and one output register. The checks therefore do not look at absolute edge times. They measure high-phase and period lengths in `clk` cycles between rising edges sampled on the falling clock edge, and they only measure after at least one full output period has passed since the last configuration change. Level results are sampled at least two cycles after their inputs settle. These are the drive enables, the held-low outputs and the inverted master clock against the F=1 bit clock.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  localparam int PRE_RATIO = 8;
  localparam int PRE_W     = $clog2(PRE_RATIO);
  localparam int SRC_XTAL  = 0;
  localparam int SRC_SYS   = 1;
  localparam int NUM_SRC   = 2;

  function automatic logic [PRE_W-1:0] pre_code(input logic pre8);
    return pre8 ? PRE_W'(PRE_RATIO - 1) : '0;
  endfunction
endpackage

// File: rtl/aclk_src_sync.sv
module aclk_src_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_src
    logic q, prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        q    <= 1'b0;
        prev <= 1'b0;
      end else begin
        q    <= src_i[g];
        prev <= q;
      end
    end
    assign lvl_o[g]  = prev;
    assign rise_o[g] = q & ~prev;
  end
endmodule

// File: rtl/aclk_count_stage.sv
module aclk_count_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic [W-1:0] code_i,
  output logic         tick_o
);
  logic [W-1:0] cnt;

  assign tick_o = tick_i && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (tick_o) cnt <= code_i;
    else if (tick_i) cnt <= cnt - 1'b1;
  end

  assert_hold_between_ticks_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cnt != $past(cnt)) |-> $past(tick_i));
endmodule

// File: rtl/aclk_frame_stage.sv
module aclk_frame_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         lvl_i,
  input  logic [W-1:0] code_i,
  output logic         lvl_o
);
  logic [W-1:0] fcnt;
  logic [W-1:0] f_act;
  logic [W:0]   thr;

  assign thr   = ({1'b0, f_act} + 1'b1) >> 1;
  assign lvl_o = (f_act == '0) ? lvl_i : ({1'b0, fcnt} >= thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt  <= '0;
      f_act <= '0;
    end else if (tick_i) begin
      if (fcnt == '0) begin
        fcnt  <= code_i;
        f_act <= code_i;
      end else begin
        fcnt <= fcnt - 1'b1;
      end
    end
  end

  assert_count_within_latched_R9: assert property (@(posedge clk) disable iff (rst)
    fcnt <= f_act);
endmodule

// File: rtl/audio_clk_divider.sv
module audio_clk_divider
  import aclk_pkg::*;
#(
  parameter int MOD_W = 8,
  parameter int FRM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xtal_i,
  input  logic             sys_i,
  input  logic             src_sel_i,
  input  logic             pre8_i,
  input  logic [MOD_W-1:0] mod_code_i,
  input  logic [FRM_W-1:0] frm_code_i,
  input  logic             bypass_i,
  input  logic             mclk_drive_i,
  input  logic             bclk_drive_i,
  input  logic             fs_drive_i,
  input  logic             mclk_inv_i,
  input  logic             bclk_inv_i,
  output logic             hck_o,
  output logic             hck_oe_o,
  output logic             sck_o,
  output logic             sck_oe_o,
  output logic             fs_oe_o
);
  logic [NUM_SRC-1:0] src_lvl, src_rise;
  logic sel_rise, pre_tick, mod_tick, hck_div;
  logic master_lvl, master_rise, bit_lvl;
  logic rst_q;

  aclk_src_sync #(.N(NUM_SRC)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .src_i  ({sys_i, xtal_i}),
    .lvl_o  (src_lvl),
    .rise_o (src_rise)
  );

  assign sel_rise = src_sel_i ? src_rise[SRC_SYS] : src_rise[SRC_XTAL];

  aclk_count_stage #(.W(PRE_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .tick_i (sel_rise),
    .code_i (pre_code(pre8_i)),
    .tick_o (pre_tick)
  );

  aclk_count_stage #(.W(MOD_W)) u_mod (
    .clk    (clk),
    .rst    (rst),
    .tick_i (pre_tick),
    .code_i (mod_code_i),
    .tick_o (mod_tick)
  );

  always_ff @(posedge clk) begin
    if (rst)           hck_div <= 1'b0;
    else if (mod_tick) hck_div <= ~hck_div;
  end

  assign master_lvl  = bypass_i ? src_lvl[SRC_XTAL]  : hck_div;
  assign master_rise = bypass_i ? src_rise[SRC_XTAL] : (mod_tick & ~hck_div);

  aclk_frame_stage #(.W(FRM_W)) u_frm (
    .clk    (clk),
    .rst    (rst),
    .tick_i (master_rise),
    .lvl_i  (master_lvl),
    .code_i (frm_code_i),
    .lvl_o  (bit_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hck_o    <= 1'b0;
      hck_oe_o <= 1'b0;
      sck_o    <= 1'b0;
      sck_oe_o <= 1'b0;
      fs_oe_o  <= 1'b0;
      rst_q    <= 1'b1;
    end else begin
      hck_o    <= mclk_drive_i & (master_lvl ^ mclk_inv_i);
      hck_oe_o <= mclk_drive_i;
      sck_o    <= bclk_drive_i & (bit_lvl ^ bclk_inv_i);
      sck_oe_o <= bclk_drive_i;
      fs_oe_o  <= fs_drive_i;
      rst_q    <= 1'b0;
    end
  end

  // Halving stage only toggles on a modulus terminal count (R1)
  assert_half_on_terminal_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && hck_div != $past(hck_div)) |-> $past(mod_tick));

  assert_bypass_follows_xtal_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(bypass_i) && $past(mclk_drive_i) && !$past(mclk_inv_i) &&
     !$past(rst) && !$past(rst, 2) && !$past(rst, 3)) |-> (hck_o == $past(xtal_i, 3)));

  assert_undriven_low_R7: assert property (@(posedge clk) disable iff (rst)
    !mclk_drive_i |=> (!hck_o && !hck_oe_o));

  always @(posedge clk) begin
    if (rst_q) begin
      assert_low_in_reset_R10: assert (!hck_o && !hck_oe_o && !sck_o && !sck_oe_o && !fs_oe_o);
    end
  end
endmodule

// File: tb/audio_clk_divider_test.sv
module audio_clk_divider_test;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 40000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xtal = 1'b0, sysc = 1'b0;
  logic src_sel = 1'b0, pre8 = 1'b0, bypass = 1'b0;
  logic [7:0] mod_code = 8'd0;
  logic [3:0] frm_code = 4'd1;
  logic mdrv = 1'b1, bdrv = 1'b1, fdrv = 1'b0, minv = 1'b0, binv = 1'b0;
  logic hck, hck_oe, sck, sck_oe, fs_oe;
  int checks = 0, failures = 0;

  audio_clk_divider uut (
    .clk(clk), .rst(rst), .xtal_i(xtal), .sys_i(sysc), .src_sel_i(src_sel),
    .pre8_i(pre8), .mod_code_i(mod_code), .frm_code_i(frm_code), .bypass_i(bypass),
    .mclk_drive_i(mdrv), .bclk_drive_i(bdrv), .fs_drive_i(fdrv),
    .mclk_inv_i(minv), .bclk_inv_i(binv),
    .hck_o(hck), .hck_oe_o(hck_oe), .sck_o(sck), .sck_oe_o(sck_oe), .fs_oe_o(fs_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // crystal: period 4 clk cycles; system: period 6 clk cycles
  initial forever begin repeat (2) @(negedge clk); xtal = ~xtal; end
  initial forever begin repeat (3) @(negedge clk); sysc = ~sysc; end

  initial begin
    #(CLK_PERIOD * 190000);
    failures++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic samp(input int which);
    return (which == 0) ? hck : sck;
  endfunction

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(input int which, output int hi, output int per);
    int guard = 0;
    int lo = 0;
    hi = 0;
    @(negedge clk);
    while (samp(which) == 1'b1 && guard < LIMIT) begin @(negedge clk); guard++; end
    while (samp(which) == 1'b0 && guard < LIMIT) begin @(negedge clk); guard++; end
    while (samp(which) == 1'b1 && guard < LIMIT) begin hi++; @(negedge clk); guard++; end
    while (samp(which) == 1'b0 && guard < LIMIT) begin lo++; @(negedge clk); guard++; end
    per = hi + lo;
    if (guard >= LIMIT) begin hi = -1; per = -1; end
  endtask

  task automatic settle_measure(input int which, output int hi, output int per);
    int h0, p0;
    measure(which, h0, p0);
    measure(which, hi, per);
  endtask

  task automatic t_reset_state;
    repeat (3) @(negedge clk);
    check_eq("R10 reset outputs", int'({hck, hck_oe, sck, sck_oe, fs_oe}), 0);
    rst = 1'b0;
  endtask

  task automatic t_basic_ratio;
    int hi, per;
    pre8 = 0; mod_code = 0; frm_code = 1; src_sel = 0; bypass = 0;
    settle_measure(0, hi, per);
    check_eq("R1 master period P1 M1", per, 8);
    check_eq("R1 master high", hi, 4);
    settle_measure(1, hi, per);
    check_eq("R4 bit period F2", per, 16);
    check_eq("R4 bit high F2", hi, 8);
  endtask

  task automatic t_prescale;
    int hi, per;
    pre8 = 1; mod_code = 2;
    settle_measure(0, hi, per);
    check_eq("R2 master period P8 M3", per, 192);
    check_eq("R2 master high P8 M3", hi, 96);
    pre8 = 0;
  endtask

  task automatic t_modulus_max;
    int hi, per;
    mod_code = 8'd255;
    settle_measure(0, hi, per);
    check_eq("R3 master period M256", per, 2048);
    mod_code = 0;
  endtask

  task automatic t_sys_source;
    int hi, per;
    src_sel = 1; mod_code = 1;
    settle_measure(0, hi, per);
    check_eq("R1 system source period", per, 24);
    check_eq("R1 system source high", hi, 12);
    src_sel = 0; mod_code = 0;
  endtask

  task automatic t_odd_frame;
    int hi, per;
    frm_code = 2;
    settle_measure(1, hi, per);
    check_eq("R5 bit period F3", per, 24);
    check_eq("R5 bit high F3", hi, 16);
    frm_code = 0;
    settle_measure(1, hi, per);
    check_eq("R5 bit period F1", per, 8);
    check_eq("R5 bit high F1", hi, 4);
  endtask

  task automatic t_bypass;
    int hi, per;
    bypass = 1; src_sel = 1; mod_code = 8'd7; pre8 = 1; frm_code = 4;
    settle_measure(0, hi, per);
    check_eq("R6 bypass master period", per, 4);
    check_eq("R6 bypass master high", hi, 2);
    settle_measure(1, hi, per);
    check_eq("R6 bypass bit period F5", per, 20);
    check_eq("R6 bypass bit high F5", hi, 12);
    bypass = 0; src_sel = 0; mod_code = 0; pre8 = 0; frm_code = 1;
  endtask

  task automatic t_direction;
    int highs = 0;
    int hi, per;
    mdrv = 0; fdrv = 1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 40; i++) begin @(negedge clk); highs += int'(hck) + int'(hck_oe); end
    check_eq("R7 master undriven low", highs, 0);
    check_eq("R7 frame sync enable", int'(fs_oe), 1);
    measure(1, hi, per);
    check_eq("R7 bit clock still driven", per, 16);
    mdrv = 1; bdrv = 0; fdrv = 0;
    repeat (3) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); highs += int'(sck) + int'(sck_oe); end
    check_eq("R7 bit undriven low", highs, 0);
    check_eq("R7 frame sync disabled", int'(fs_oe), 0);
    check_eq("R7 master enable back", int'(hck_oe), 1);
    bdrv = 1;
  endtask

  task automatic t_invert;
    int same = 0;
    int hi, per;
    frm_code = 0; minv = 1; binv = 0;
    measure(1, hi, per); measure(1, hi, per);
    for (int i = 0; i < 40; i++) begin @(negedge clk); same += int'(hck == sck); end
    check_eq("R8 master inverted vs bit", same, 0);
    minv = 0; binv = 1; frm_code = 2;
    settle_measure(1, hi, per);
    check_eq("R8 inverted bit high F3", hi, 8);
    check_eq("R8 inverted bit period F3", per, 24);
    binv = 0; frm_code = 1;
  endtask

  task automatic t_glitch_free;
    int hi, per;
    int bad = 0;
    mod_code = 8'd9;
    settle_measure(0, hi, per);
    check_eq("R9 old period before change", per, 80);
    repeat (13) @(negedge clk);
    mod_code = 8'd1;
    for (int i = 0; i < 6; i++) begin
      measure(0, hi, per);
      if (hi != 8 && hi != 40) bad++;
    end
    check_eq("R9 no shortened phase", bad, 0);
    check_eq("R9 new high after change", hi, 8);
    mod_code = 0;
  endtask

  task automatic t_reset_midrun;
    int highs = 0;
    int hi, per;
    @(negedge clk); rst = 1;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin @(negedge clk); highs += int'(hck) + int'(sck) + int'(hck_oe) + int'(sck_oe); end
    check_eq("R10 mid-run reset low", highs, 0);
    rst = 0;
    settle_measure(0, hi, per);
    check_eq("R10 restart period", per, 8);
  endtask

  initial begin
    t_reset_state();
    t_basic_ratio();
    t_prescale();
    t_modulus_max();
    t_sys_source();
    t_odd_frame();
    t_bypass();
    t_direction();
    t_invert();
    t_glitch_free();
    t_reset_midrun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule